// File: doc/BRIEF.md
# Programmable Dual-Digit Divide-by-N Counter

This block divides a clock by a programmable ratio N. It is a synchronous down counter made of two 4-bit digit stages. The lower digit decrements on every rising clock edge, and the upper digit decrements only when the lower digit borrows. Each digit has its own mode bit, which selects binary counting (0 to 15) or BCD counting (0 to 9). The four mode pairs therefore give full ranges of 256, 160, 160 and 100.

The count is loaded from the 8-bit preset when it reaches 1, so the output period is exactly N clocks and a ratio of 1 cannot be produced. A preset of zero gives the full range of the selected mode pair. When the cascade-feedback input is low, the preset is not used: the reload value is zero and the block divides by the full range. The zero-detect output pulses for one clock per period. Output `q` is the most significant bit of the upper digit.

Top module: `divn_counter`

## Requirements
- R1: While not in reset, the count value falls by one on each rising clock edge. After N edges the zero-detect pulse repeats.
- R2: A digit in binary mode (mode bit 0) wraps from 0 to 15 when it borrows. With both digits binary, preset 0x23 divides by 35.
- R3: A digit in BCD mode (mode bit 1) wraps from 0 to 9 when it borrows. `bcdMode[0]` selects the lower digit. With the lower digit BCD and the upper digit binary, preset 0x23 divides by 23.
- R4: `bcdMode[1]` selects the upper digit. With the lower digit binary and the upper digit BCD, preset 0x45 divides by 69.
- R5: The preset is reloaded in the clock after the count reaches 1. Presets 2 and 3 divide by 2 and 3.
- R6: `zeroDet` is high for exactly one clock per period, in the cycle where the count equals 1. It is low at all other times, including during reset.
- R7: A preset of 0x00 divides by 256, 160, 160 and 100 for mode pairs (lower,upper) = binary/binary, BCD/binary, binary/BCD and BCD/BCD.
- R8: While `cascadeFb` is low, the preset is ignored, including changes made during a period. The reload value is 0, and the ratio is 256 for binary/binary and 100 for BCD/BCD.
- R9: `q` equals bit 3 of the upper digit (count weight 8 of that digit). It stays low while preset bit 7 is low and the preset is nonzero.
- R10: While `rstN` is low, the count is loaded on every clock and `zeroDet` is low. After release, the first pulse falls in the Nth clock cycle, counting the release cycle as the first.
- R11: The largest legal presets give the largest ratios: 0xFF gives 255 (binary/binary), 0xF9 gives 159 (BCD lower), 0x9F gives 159 (BCD upper) and 0x99 gives 99 (BCD/BCD).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge count clock |
| rstN | input | 1 | Synchronous active-low reset; loads the reload value |
| preset | input | 8 | Divide ratio N; [3:0] is the lower digit, [7:4] is the upper digit |
| bcdMode | input | 2 | Per-digit mode; bit 0 is the lower digit, bit 1 is the upper digit; 1 selects BCD |
| cascadeFb | input | 1 | High: reload from preset. Low: reload zero (full range) |
| zeroDet | output | 1 | One-clock pulse per period |
| q | output | 1 | Most significant bit of the upper digit |

## Verification
The assertions assume that the preset is never 1 and that a BCD digit never receives a preset nibble above 9. They also assume that the mode bits change only while reset is held, so that a BCD digit always holds a value from 0 to 9. The stimulus meets these assumptions. Every phase starts with a reset, during which the modes and the preset are set. Only legal presets are used. The single mid-period preset change happens with `cascadeFb` low, so that value never reaches the counter.

// File: rtl/divn_pkg.sv
package divn_pkg;
  typedef struct packed {
    logic load;     // reload the count this edge
    logic dec;      // decrement the count this edge
    logic zeroSel;  // reload value is zero rather than the preset
  } divn_strobe_t;
endpackage

// File: rtl/divn_digit.sv
module divn_digit #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [DIGIT_W-1:0] loadVal,
  input  logic               borrowIn,
  input  logic               bcdMode,
  output logic [DIGIT_W-1:0] value,
  output logic               borrowOut
);
  localparam logic [DIGIT_W-1:0] BinTop = '1;
  localparam logic [DIGIT_W-1:0] BcdTop = DIGIT_W'(9);

  logic [DIGIT_W-1:0] nextVal;
  logic               atZero;

  assign atZero    = (value == '0);
  assign borrowOut = borrowIn & atZero;

  always_comb begin
    if (load)          nextVal = loadVal;
    else if (borrowIn) nextVal = atZero ? (bcdMode ? BcdTop : BinTop) : value - 1'b1;
    else               nextVal = value;
  end

  always_ff @(posedge clk) value <= nextVal;

  // R1: a digit told to step always moves
  p_digit_moves_r1: assert property (@(posedge clk) disable iff (!rstN)
    (borrowIn && !load) |=> (value != $past(value)));

  // R3: a BCD digit stays inside 0..9
  p_bcd_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    bcdMode |-> (value <= BcdTop));
endmodule

// File: rtl/divn_datapath.sv
module divn_datapath
  import divn_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter int DIGIT_W    = 4,
  localparam int CountW    = NUM_DIGITS * DIGIT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  divn_strobe_t          strobe,
  input  logic [CountW-1:0]     preset,
  input  logic [NUM_DIGITS-1:0] bcdMode,
  output logic [CountW-1:0]     count,
  output logic                  isOne
);
  logic [CountW-1:0]   reloadVal;
  logic [NUM_DIGITS:0] borrowChain;

  assign reloadVal      = strobe.zeroSel ? '0 : preset;
  assign borrowChain[0] = strobe.dec;
  assign isOne          = (count == CountW'(1));

  for (genvar d = 0; d < NUM_DIGITS; d++) begin : g_digit
    divn_digit #(.DIGIT_W(DIGIT_W)) i_digit (
      .clk      (clk),
      .rstN     (rstN),
      .load     (strobe.load),
      .loadVal  (reloadVal[d*DIGIT_W +: DIGIT_W]),
      .borrowIn (borrowChain[d]),
      .bcdMode  (bcdMode[d]),
      .value    (count[d*DIGIT_W +: DIGIT_W]),
      .borrowOut(borrowChain[d+1])
    );
  end

  // R5: reaching one brings in the reload value on the next edge
  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    isOne |=> (count == ($past(strobe.zeroSel) ? '0 : $past(preset))));
endmodule

// File: rtl/divn_ctrl.sv
module divn_ctrl
  import divn_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cascadeFb,
  input  logic         isOne,
  output divn_strobe_t strobe,
  output logic         zeroDet
);
  always_comb begin
    strobe.load    = !rstN || isOne;
    strobe.dec     = !strobe.load;
    strobe.zeroSel = !cascadeFb;
  end

  assign zeroDet = rstN && isOne;

  // R6: the pulse never lasts two clocks
  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    zeroDet |=> !zeroDet);
endmodule

// File: rtl/divn_counter.sv
module divn_counter
  import divn_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  parameter int DIGIT_W    = 4,
  localparam int CountW    = NUM_DIGITS * DIGIT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CountW-1:0]     preset,
  input  logic [NUM_DIGITS-1:0] bcdMode,
  input  logic                  cascadeFb,
  output logic                  zeroDet,
  output logic                  q
);
  divn_strobe_t      strobe;
  logic [CountW-1:0] count;
  logic              isOne;

  divn_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cascadeFb(cascadeFb),
    .isOne    (isOne),
    .strobe   (strobe),
    .zeroDet  (zeroDet)
  );

  divn_datapath #(.NUM_DIGITS(NUM_DIGITS), .DIGIT_W(DIGIT_W)) i_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .preset (preset),
    .bcdMode(bcdMode),
    .count  (count),
    .isOne  (isOne)
  );

  assign q = count[CountW-1];
endmodule

// File: tb/test_divn_counter.sv
module test_divn_counter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] preset = 8'h02;
  logic [1:0] bcdMode = 2'b00;
  logic       cascadeFb = 1'b1;
  logic       zeroDet, q;

  int errors = 0;
  int checks = 0;
  int expQ[$];
  string tagQ[$];
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  divn_counter i_divn_counter (
    .clk(clk), .rstN(rstN), .preset(preset), .bcdMode(bcdMode),
    .cascadeFb(cascadeFb), .zeroDet(zeroDet), .q(q));

  function automatic int radix(input logic b);
    return b ? 10 : 16;
  endfunction

  function automatic int ratioOf(input logic [7:0] p, input logic [1:0] m, input logic fb);
    int v;
    v = int'(p[7:4]) * radix(m[0]) + int'(p[3:0]);
    if (!fb || v == 0) v = radix(m[0]) * radix(m[1]);
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: reference count model plus interval scoreboard
  initial begin
    int v = 0;
    int cyc = 0;
    int rl, mo, pv, eq, exp;
    string tg;
    forever begin
      @(posedge clk);
      rl = radix(bcdMode[0]);
      mo = rl * radix(bcdMode[1]);
      pv = int'(preset[7:4]) * rl + int'(preset[3:0]);
      if (!rstN || v == 1) v = cascadeFb ? pv : 0;
      else v = (v == 0) ? mo - 1 : v - 1;
      if (!rstN) cyc = 1; else cyc++;
      #5;
      check(zeroDet == (rstN && v == 1), "R6", int'(zeroDet), int'(rstN && v == 1));
      eq = ((v / rl) >> 3) & 1;
      check(q == eq[0], "R9", int'(q), eq);
      if (zeroDet) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected pulse", cyc, 0);
        end else begin
          exp = expQ.pop_front();
          tg = tagQ.pop_front();
          check(cyc == exp, tg, cyc, exp);
        end
        cyc = 0;
      end
    end
  end

  // driver: one reset-started phase per configuration
  task automatic runPhase(input logic [7:0] p, input logic [1:0] m, input logic fb,
                          input int pulses, input string tag);
    int n;
    @(negedge clk);
    rstN = 1'b0; preset = p; bcdMode = m; cascadeFb = fb;
    repeat (2) @(negedge clk);
    n = ratioOf(p, m, fb);
    expQ.push_back(n); tagQ.push_back({"R10 ", tag});
    for (int i = 1; i < pulses; i++) begin
      expQ.push_back(n); tagQ.push_back(tag);
    end
    rstN = 1'b1;
    wait (expQ.size() == 0);
  endtask

  initial begin
    runPhase(8'h23, 2'b00, 1'b1, 3, "R1 R2 binary pair");
    runPhase(8'h23, 2'b01, 1'b1, 3, "R3 lower BCD");
    runPhase(8'h45, 2'b10, 1'b1, 3, "R4 upper BCD");
    runPhase(8'h02, 2'b00, 1'b1, 5, "R5 ratio two");
    runPhase(8'h03, 2'b11, 1'b1, 4, "R5 ratio three");
    runPhase(8'h00, 2'b00, 1'b1, 2, "R7 zero preset 256");
    runPhase(8'h00, 2'b01, 1'b1, 2, "R7 zero preset 160a");
    runPhase(8'h00, 2'b10, 1'b1, 2, "R7 zero preset 160b");
    runPhase(8'h00, 2'b11, 1'b1, 2, "R7 zero preset 100");
    runPhase(8'hFF, 2'b00, 1'b1, 2, "R11 max 255");
    runPhase(8'hF9, 2'b01, 1'b1, 2, "R11 max 159a");
    runPhase(8'h9F, 2'b10, 1'b1, 2, "R11 max 159b");
    runPhase(8'h99, 2'b11, 1'b1, 2, "R11 max 99");
    runPhase(8'h90, 2'b00, 1'b1, 2, "R9 q active");
    runPhase(8'h37, 2'b11, 1'b0, 2, "R8 feedback low 100");
    // R8: preset change during a period with feedback low has no effect
    @(negedge clk);
    rstN = 1'b0; preset = 8'h23; bcdMode = 2'b00; cascadeFb = 1'b0;
    repeat (2) @(negedge clk);
    expQ.push_back(256); tagQ.push_back("R10 R8 feedback low");
    expQ.push_back(256); tagQ.push_back("R8 preset ignored");
    rstN = 1'b1;
    repeat (100) @(negedge clk);
    preset = 8'h05;
    wait (expQ.size() == 0);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule